// File: doc/BRIEF.md
# Banked video memory host port

This block turns host word accesses into requests on a two-bank video memory that lies outside it. Each access presents a byte address, an access size in bytes, a write enable and write data. The block decides whether the access is legal, and if it is, where it goes. A legal access can go to a word in one of the banks. It can go to a 16-word control window that the timing logic may place anywhere in the address space. It can also go to a 16-entry palette that is fed through a single write address. The palette index moves on by one after every palette write.

The timing logic supplies the current bank number and the word base of the control window. The control window takes priority over the bank: a hit on it always lands on memory words 0 to 15. Every access gets a response one cycle later. That response carries the read data and an error flag. An illegal access touches nothing: no memory request, no palette write and no index step. The palette entries can be read on a side port for debug.

Top module: `vmem_host_port`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid_o` and `err_o` are 0, the palette index is 0 and every palette entry reads 0.
- R2: An access whose size is not 2 bytes (`size_i` != 2) or whose byte address is odd (`addr_i[0]` = 1) is an error.
- R3: An access with `bank_i` of 2 or more is an error, even at the palette address.
- R4: The word offset is `addr_i` shifted right by one. An offset of 0x10000 or above is an error, except a write at offset 0x40000. A read at offset 0x40000 is an error.
- R5: A legal offset `o` with `reg_base_i` <= `o` < `reg_base_i`+16 and `o` < 0x10000 drives a memory request at word `o - reg_base_i`, whatever the bank.
- R6: Any other legal offset below 0x10000 drives a memory request at word `bank_i`*0x10000 + `o`. `mem_we_o` follows `we_i` and `mem_wdata_o` carries `wdata_i`.
- R7: A legal write at offset 0x40000 makes no memory request. It stores `wdata_i` into the palette entry at the current index, and the index then steps by one, going from 15 back to 0.
- R8: Each cycle with `req_i` high is followed by one cycle with `rsp_valid_o` high. `rdata_o` then holds the memory word for a legal read, and 0 for writes and errors. `rsp_valid_o` stays low after a cycle without a request.
- R9: An erroneous access makes no memory request and leaves the palette unchanged. It raises `err_o` for exactly the response cycle, with `rdata_o` at 0.
- R10: `pal_dbg_data_o` shows the palette entry selected by `pal_dbg_idx_i`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Host byte address |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 16 | Write data |
| bank_i | input | 2 | Current bank from the timing logic |
| reg_base_i | input | 23 | Word base of the control window |
| rsp_valid_o | output | 1 | Response cycle, one after each request |
| rdata_o | output | 16 | Read data |
| err_o | output | 1 | Error flag for the response |
| mem_en_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 17 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the request |
| pal_dbg_idx_i | input | 4 | Palette entry to show |
| pal_dbg_data_o | output | 16 | Selected palette entry |

## Verification
The bench builds the block with its default parameters: a 64K-word window, two banks on a 2-bit bank input, a 16-word control window, 16 palette entries and the palette at offset 0x40000. The memory is modelled in the bench, so the real 0xFFFF/0x10000 edge is reachable, and so are bank numbers 2 and 3, which exist on the port but are illegal. The control window base is set to values that straddle the 64K edge and that cover the palette offset. That exposes the order of the error, palette, window and bank decisions, and more than 16 palette writes wrap the index.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam logic [2:0] ACC_LEGAL_BYTES = 3'd2;

  typedef enum logic [1:0] {
    ACC_ERR  = 2'd0,
    ACC_PAL  = 2'd1,
    ACC_WIN  = 2'd2,
    ACC_BANK = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/vmem_decode.sv
module vmem_decode
  import vmem_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int WIN_AW    = 16,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 2,
  parameter int REG_WORDS = 16,
  parameter int PAL_WOFF  = 32'h40000,
  localparam int WOFF_W   = ADDR_W - 1,
  localparam int MEM_AW   = WIN_AW + $clog2(NUM_BANKS)
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [WOFF_W-1:0] reg_base_i,
  output acc_kind_e         kind_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  logic [WOFF_W-1:0] woff;
  logic [WOFF_W:0]   off_x, base_x, lim_x;
  logic shape_ok, bank_ok, in_win, pal_hit, win_hit;

  assign woff     = addr_i[ADDR_W-1:1];
  assign off_x    = {1'b0, woff};
  assign base_x   = {1'b0, reg_base_i};
  assign lim_x    = base_x + (WOFF_W+1)'(REG_WORDS);
  assign shape_ok = (size_i == ACC_LEGAL_BYTES) && !addr_i[0];
  assign bank_ok  = 32'(bank_i) < NUM_BANKS;
  assign in_win   = (woff >> WIN_AW) == '0;
  assign pal_hit  = we_i && (woff == WOFF_W'(PAL_WOFF));
  assign win_hit  = (off_x >= base_x) && (off_x < lim_x);

  // order: shape/bank errors, out-of-window (palette or error), control window, bank
  always_comb begin
    kind_o     = ACC_ERR;
    mem_addr_o = '0;
    if (shape_ok && bank_ok) begin
      if (!in_win) begin
        if (pal_hit) kind_o = ACC_PAL;
      end else if (win_hit) begin
        kind_o     = ACC_WIN;
        mem_addr_o = MEM_AW'(woff - reg_base_i);
      end else begin
        kind_o     = ACC_BANK;
        mem_addr_o = (MEM_AW'(bank_i) << WIN_AW) | MEM_AW'(woff[WIN_AW-1:0]);
      end
    end
  end
endmodule

// File: rtl/vmem_palette.sv
module vmem_palette #(
  parameter int PAL_N  = 16,
  parameter int DATA_W = 16,
  localparam int PAL_IW = $clog2(PAL_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PAL_IW-1:0] dbg_idx_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic [PAL_IW-1:0] idx_q;
  logic [DATA_W-1:0] ent_q [PAL_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          idx_q <= '0;
    else if (we_i && idx_q == PAL_IW'(PAL_N-1)) idx_q <= '0;
    else if (we_i)                        idx_q <= idx_q + 1'b1;
  end

  for (genvar i = 0; i < PAL_N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_q[i] <= '0;
      else if (we_i && idx_q == PAL_IW'(i))      ent_q[i] <= wdata_i;
    end
  end

  assign dbg_data_o = ent_q[dbg_idx_i];

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> idx_q == (($past(idx_q) == PAL_IW'(PAL_N-1)) ? PAL_IW'(0) : PAL_IW'($past(idx_q) + 1'b1))); // R7
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(idx_q)); // R9
endmodule

// File: rtl/vmem_rsp.sv
module vmem_rsp #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              err_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      rd_q        <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= req_i && err_i;
      rd_q        <= req_i && rd_i;
    end
  end

  assign rdata_o = rd_q ? mem_rdata_i : '0;

  AST_ERR_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_o); // R9
endmodule

// File: rtl/vmem_host_port.sv
module vmem_host_port
  import vmem_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int WIN_AW    = 16,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 2,
  parameter int REG_WORDS = 16,
  parameter int PAL_N     = 16,
  parameter int PAL_WOFF  = 32'h40000,
  localparam int WOFF_W   = ADDR_W - 1,
  localparam int MEM_AW   = WIN_AW + $clog2(NUM_BANKS),
  localparam int PAL_IW   = $clog2(PAL_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [WOFF_W-1:0] reg_base_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [PAL_IW-1:0] pal_dbg_idx_i,
  output logic [DATA_W-1:0] pal_dbg_data_o
);
  acc_kind_e         kind;
  logic [MEM_AW-1:0] dec_addr;
  logic              pal_we;

  vmem_decode #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
    .REG_WORDS(REG_WORDS), .PAL_WOFF(PAL_WOFF)
  ) u_decode (
    .we_i(we_i), .addr_i(addr_i), .size_i(size_i), .bank_i(bank_i),
    .reg_base_i(reg_base_i), .kind_o(kind), .mem_addr_o(dec_addr)
  );

  assign mem_en_o    = req_i && (kind == ACC_WIN || kind == ACC_BANK);
  assign mem_we_o    = mem_en_o && we_i;
  assign mem_addr_o  = mem_en_o ? dec_addr : '0;
  assign mem_wdata_o = wdata_i;
  assign pal_we      = req_i && (kind == ACC_PAL);

  vmem_palette #(.PAL_N(PAL_N), .DATA_W(DATA_W)) u_palette (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(pal_we), .wdata_i(wdata_i),
    .dbg_idx_i(pal_dbg_idx_i), .dbg_data_o(pal_dbg_data_o)
  );

  vmem_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .err_i(kind == ACC_ERR),
    .rd_i(mem_en_o && !we_i), .mem_rdata_i(mem_rdata_i),
    .rsp_valid_o(rsp_valid_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R8
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !err_o); // R8
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R9
  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && kind == ACC_WIN |-> mem_addr_o < MEM_AW'(REG_WORDS)); // R5
  AST_BANK_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && kind == ACC_BANK |-> (mem_addr_o >> WIN_AW) == MEM_AW'(bank_i)); // R6
endmodule

// File: tb/vmem_host_port_test.sv
`timescale 1ns/1ps
module vmem_host_port_test;
  localparam int PAL_WOFF = 32'h40000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [2:0]  size_i = 3'd2;
  logic [15:0] wdata_i = '0;
  logic [1:0]  bank_i = '0;
  logic [22:0] reg_base_i = '0;
  logic        rsp_valid_o, err_o, mem_en_o, mem_we_o;
  logic [15:0] rdata_o, mem_wdata_o, pal_dbg_data_o;
  logic [15:0] mem_rdata_i = '0;
  logic [16:0] mem_addr_o;
  logic [3:0]  pal_dbg_idx_i = '0;

  always #2 clk_i = ~clk_i;

  vmem_host_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .bank_i(bank_i), .reg_base_i(reg_base_i),
    .rsp_valid_o(rsp_valid_o), .rdata_o(rdata_o), .err_o(err_o), .mem_en_o(mem_en_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .pal_dbg_idx_i(pal_dbg_idx_i), .pal_dbg_data_o(pal_dbg_data_o)
  );

  // external memory model, one cycle read latency
  logic [15:0] mem_m [int];
  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) mem_m[int'(mem_addr_o)] = mem_wdata_o;
      else mem_rdata_i <= mem_m.exists(int'(mem_addr_o)) ? mem_m[int'(mem_addr_o)] : 16'h0;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] sh_mem [int];
  logic [15:0] sh_pal [16];
  int sh_idx = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 error, 1 palette, 2 window, 3 bank
  function automatic int model(input bit we, input logic [23:0] a, input logic [2:0] sz,
                               input logic [1:0] bk, input logic [22:0] base,
                               output int maddr, output string etag);
    int off = int'(a >> 1);
    maddr = 0;
    etag = "R4";
    if (sz != 3'd2 || a[0]) begin etag = "R2"; return 0; end
    if (bk >= 2) begin etag = "R3"; return 0; end
    if (off >= 32'h10000) return (we && off == PAL_WOFF) ? 1 : 0;
    if (off >= int'(base) && off < int'(base) + 16) begin
      maddr = off - int'(base);
      return 2;
    end
    maddr = int'(bk) * 32'h10000 + off;
    return 3;
  endfunction

  task automatic access(input bit we, input logic [23:0] a, input logic [2:0] sz,
                        input logic [1:0] bk, input logic [15:0] wd);
    int ea, k;
    string etag, mtag;
    logic [15:0] exp_rd;
    k = model(we, a, sz, bk, reg_base_i, ea, etag);
    mtag = (k == 0) ? etag : (k == 1) ? "R7" : (k == 2) ? "R5" : "R6";
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; bank_i = bk; wdata_i = wd;
    #1;
    chk(mem_en_o == (k >= 2), mtag, "mem_en", 32'(mem_en_o), 32'(k >= 2));
    if (k >= 2) begin
      chk(mem_addr_o == 17'(ea), mtag, "mem_addr", 32'(mem_addr_o), 32'(ea));
      chk(mem_we_o == we && (!we || mem_wdata_o == wd), "R6", "mem_we/wdata",
          {mem_we_o, 15'd0, mem_wdata_o}, {we, 15'd0, wd});
    end
    @(posedge clk_i); #1;
    req_i = 1'b0;
    exp_rd = (k >= 2 && !we && sh_mem.exists(ea)) ? sh_mem[ea] : 16'h0;
    chk(rsp_valid_o == 1'b1, "R8", "rsp_valid", 32'(rsp_valid_o), 1);
    chk(err_o == (k == 0), (k == 0) ? etag : "R9", "err", 32'(err_o), 32'(k == 0));
    chk(rdata_o == exp_rd, (k == 0) ? "R9" : "R8", "rdata", 32'(rdata_o), 32'(exp_rd));
    if (k >= 2 && we) sh_mem[ea] = wd;
    if (k == 1) begin sh_pal[sh_idx] = wd; sh_idx = (sh_idx + 1) % 16; end
    @(posedge clk_i); #1;
    chk(!rsp_valid_o && !err_o, "R9", "err one cycle", {rsp_valid_o, err_o}, 0);
  endtask

  task automatic check_palette(input string tag);
    for (int i = 0; i < 16; i++) begin
      pal_dbg_idx_i = 4'(i);
      #1;
      chk(pal_dbg_data_o == sh_pal[i], tag, "palette entry", 32'(pal_dbg_data_o), 32'(sh_pal[i]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [22:0] bases [6];
    bases = '{23'h0, 23'h10, 23'h1230, 23'hFFF8, 23'h20000, 23'h3FFF8};
    for (int i = 0; i < 16; i++) sh_pal[i] = 16'h0;
    void'($urandom(32'd2024));
    #1;
    chk(!rsp_valid_o && !err_o, "R1", "reset outputs", {rsp_valid_o, err_o}, 0);
    check_palette("R1");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(!rsp_valid_o && !err_o, "R1", "after reset", {rsp_valid_o, err_o}, 0);

    // directed
    reg_base_i = 23'h10;
    access(1, 24'h40, 3'd2, 2'd0, 16'hA001);       // R6 bank 0
    access(1, 24'h40, 3'd2, 2'd1, 16'hB002);       // R6 bank 1
    access(0, 24'h40, 3'd2, 2'd0, 16'h0);
    access(0, 24'h40, 3'd2, 2'd1, 16'h0);
    access(1, 24'h26, 3'd2, 2'd1, 16'hC003);       // R5 window word 3
    access(0, 24'h26, 3'd2, 2'd0, 16'h0);          // R5 bank ignored
    access(1, 24'h1FFFE, 3'd2, 2'd1, 16'hD004);    // R6 last word
    access(0, 24'h1FFFE, 3'd2, 2'd1, 16'h0);
    access(0, 24'h20000, 3'd2, 2'd0, 16'h0);       // R4 first illegal
    access(1, 24'h20000, 3'd2, 2'd0, 16'h1111);    // R4
    access(1, 24'h41, 3'd2, 2'd0, 16'h2222);       // R2 odd
    access(1, 24'h40, 3'd1, 2'd0, 16'h2222);       // R2 byte
    access(1, 24'h40, 3'd4, 2'd0, 16'h2222);       // R2 long
    access(0, 24'h40, 3'd2, 2'd0, 16'h0);          // unchanged after errors
    access(1, 24'h40, 3'd2, 2'd2, 16'h3333);       // R3
    access(1, 24'h80000, 3'd2, 2'd3, 16'h3333);    // R3 palette write blocked
    access(0, 24'h80000, 3'd2, 2'd0, 16'h0);       // R4 palette read
    check_palette("R9");
    for (int i = 0; i < 17; i++) access(1, 24'h80000, 3'd2, 2'(i % 2), 16'(16'h5000 + i)); // R7 wrap
    check_palette("R7");
    reg_base_i = 23'hFFF8;
    access(1, 24'h20004, 3'd2, 2'd0, 16'h4444);    // R4 window beyond 64K
    access(1, 24'h1FFF4, 3'd2, 2'd1, 16'h6006);    // R5 word 2
    access(0, 24'h4, 3'd2, 2'd0, 16'h0);
    reg_base_i = 23'h3FFF8;
    access(1, 24'h80000, 3'd2, 2'd0, 16'h7007);    // R7 palette over window
    access(0, 24'h80000, 3'd2, 2'd0, 16'h0);       // R4
    check_palette("R10");

    // random
    for (int n = 0; n < 700; n++) begin
      int cat, off;
      bit we;
      logic [2:0] sz;
      logic [1:0] bk;
      logic [23:0] a;
      if (n % 50 == 0) reg_base_i = bases[$urandom_range(0, 5)];
      cat = $urandom_range(0, 9);
      we = 1'($urandom_range(0, 1));
      sz = 3'd2;
      bk = 2'($urandom_range(0, 1));
      off = $urandom_range(0, 255);
      case (cat)
        1: sz = (($urandom_range(0, 1)) != 0) ? 3'd1 : 3'd4;
        2: bk = 2'($urandom_range(2, 3));
        3: off = PAL_WOFF;
        4, 5: begin
          off = int'(reg_base_i) + $urandom_range(0, 19) - 2;
          if (off < 0) off = 0;
        end
        6: off = 32'hFFFC + $urandom_range(0, 7);
        default: ;
      endcase
      a = 24'(off * 2);
      if (cat == 0) a[0] = 1'b1;
      access(we, a, sz, bk, 16'($urandom));
    end
    check_palette("R7");
    finish_run();
  end
endmodule